// File: doc/BRIEF.md
# DAC Serial Access Engine

This block lets software reach the internal registers of an external serial DAC through a small register bus. Software sets a target address, a data word, the symbol width and the clock mode in the block's registers. It then sets a launch bit. The engine drops chip-select and shifts out an 8-bit address, most significant bit first. A data phase of 8 or 16 bits follows, in single-edge or double-edge timing. The engine then releases chip-select. A status bit stays set for the length of the access, and software polls it.

Setting the top bit of the address turns the access into a read. The engine then drives its data line low during the data phase and samples the DAC's return line, and the captured value becomes readable once busy has dropped. Two other control bits change how an access starts and ends. Stream mode keeps chip-select asserted and sends symbol after symbol from the data register until software clears it. Synchronized mode holds the start until an external sync pulse arrives.

The state machine has seven states:
- IDLE: waits for the launch bit.
- WAIT_SYNC: waits for the sync pulse.
- SELECT: a single cycle with chip-select low.
- ADDR: shifts the address byte.
- DATA: shifts one or more symbols.
- RELEASE: a single closing cycle.
- DONE: waits for software to clear the launch bit.

It makes these transitions:
- IDLE to WAIT_SYNC, on launch with the sync request set.
- IDLE to SELECT, on launch without the sync request.
- WAIT_SYNC to SELECT, when sync_in is high.
- SELECT to ADDR, always after its one cycle.
- ADDR to DATA, after the eighth address bit.
- DATA back to DATA, at the end of a symbol while stream is set. The next symbol is reloaded.
- DATA to RELEASE, at the end of a symbol while stream is clear.
- RELEASE to DONE, always after its one cycle.
- DONE to IDLE, once the launch bit reads 0.

Top module: `dac_serial_engine`

## Requirements
- R1: After reset all registers read 0, `dac_cs_n` is 1, `dac_sclk` and `dac_sdo` are 0, and the busy bit is 0.
- R2: Register map, by word index on `bus_addr`:
  - Index 0 is control. Bits [31:24] hold the target address, bit 2 requests sync, bit 1 selects stream and bit 0 launches.
  - Index 1 is mode. Bit 16 set selects SDR and clear selects DDR. Bit 14 set selects 8-bit symbols and clear selects 16-bit symbols.
  - Index 2 is write data.
  - Index 3 is status, with busy in bit 4.
  - Index 4 is read data, in bits [15:0].
  - Indices 0 to 2 read back exactly what was written.
- R3: In IDLE, a launch bit of 1 moves the engine to SELECT at the next clock edge. In SELECT, chip-select is low and sclk and sdo are low for one cycle. Busy reads 1 from SELECT through RELEASE.
- R4: The address phase sends the 8 bits of control [31:24] MSB first. Each bit takes two cycles, the first with sclk 0 and the second with sclk 1, and sdo is held across both.
- R5: A 16-bit write sends write-data [23:8] MSB first. An 8-bit write sends write-data [23:16]. Write-data bits [15:8] have no effect on an 8-bit access.
- R6: In SDR mode each data bit takes two cycles, with the same sclk pattern as the address phase.
- R7: In DDR mode each data bit takes one cycle, and sclk toggles every cycle starting at 0. A symbol therefore takes half the cycles it takes in SDR.
- R8: After the last data bit there is one cycle with chip-select, sclk and sdo all low. Then chip-select returns to 1 and busy to 0.
- R9: After completion the engine stays idle-looking (chip-select 1, busy 0) and starts nothing new while the launch bit is still 1. Once the bit is cleared, a fresh launch starts a new access.
- R10: An address with bit 7 set is a read. During its data phase sdo is 0, and `dac_sdi` is sampled at the clock edge that ends each data bit. The bits are read MSB first and placed right-justified in read data, which is valid when busy reads 0.
- R11: With stream and launch both set, each symbol that ends while stream is still 1 is followed at once by another symbol. That symbol takes the write-data value current at that moment, with no new address, and chip-select stays low. A symbol that ends with stream at 0 goes on to RELEASE.
- R12: With the sync bit set, a launch waits with chip-select 1 and busy 1 until `sync_in` is seen high at a clock edge. SELECT follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| sync_in | input | 1 | External start pulse for synchronized accesses |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_cs_n | output | 1 | Active-low chip-select |
| dac_sdo | output | 1 | Serial data to the DAC |
| dac_sdi | input | 1 | Serial data from the DAC |

## Verification
The hardest situation to reach from the ports is a stream access, where symbols must chain back to back. That needs two register writes during the transfer, placed at exact cycles. A new write-data value must land during the first symbol. The stream bit must be cleared during the second symbol, so that the second symbol is the last one. The bench builds the expected waveform for the whole access in a queue, one entry per clock. It schedules those two writes at fixed queue indices, so the symbol boundary and the release cycle can be compared exactly. Read returns are handled the same way: the bench drives `dac_sdi` from the same queue, bit by bit, in step with the expected data-phase cycles.

// File: rtl/dse_pkg.sv
package dse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SYNC,
        ST_SELECT,
        ST_ADDR,
        ST_DATA,
        ST_RELEASE,
        ST_DONE
    } dse_state_t;

    // register word indices
    localparam int REG_CTRL   = 0;
    localparam int REG_MODE   = 1;
    localparam int REG_WDATA  = 2;
    localparam int REG_STATUS = 3;
    localparam int REG_RDATA  = 4;

    // control bits
    localparam int CTRL_GO       = 0;
    localparam int CTRL_STREAM   = 1;
    localparam int CTRL_SYNC     = 2;
    localparam int CTRL_ADDR_LSB = 24;

    // mode bits
    localparam int MODE_SYM8 = 14;
    localparam int MODE_SDR  = 16;

    // status bits
    localparam int STATUS_BUSY = 4;

    // top bit of the payload window in the write-data register
    localparam int WDATA_MSB = 23;

endpackage

// File: rtl/dse_regs.sv
module dse_regs
    import dse_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int BUS_AW = 3,
    parameter int ADDR_W = 8,
    parameter int SYM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              rd_commit,
    input  logic [SYM_W-1:0]  rd_value,
    output logic              go,
    output logic              stream,
    output logic              sync_req,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              sdr,
    output logic              sym8,
    output logic [SYM_W-1:0]  wpayload
);

    logic [BUS_W-1:0] ctrl_q;
    logic [BUS_W-1:0] mode_q;
    logic [BUS_W-1:0] wdata_q;
    logic [SYM_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mode_q  <= '0;
            wdata_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == BUS_AW'(REG_CTRL))  ctrl_q  <= bus_wdata;
            if (bus_addr == BUS_AW'(REG_MODE))  mode_q  <= bus_wdata;
            if (bus_addr == BUS_AW'(REG_WDATA)) wdata_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_commit) begin
            rdata_q <= rd_value;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            BUS_AW'(REG_CTRL):   bus_rdata = ctrl_q;
            BUS_AW'(REG_MODE):   bus_rdata = mode_q;
            BUS_AW'(REG_WDATA):  bus_rdata = wdata_q;
            BUS_AW'(REG_STATUS): bus_rdata[STATUS_BUSY] = busy;
            BUS_AW'(REG_RDATA):  bus_rdata = BUS_W'(rdata_q);
            default:             bus_rdata = '0;
        endcase
    end

    assign go       = ctrl_q[CTRL_GO];
    assign stream   = ctrl_q[CTRL_STREAM];
    assign sync_req = ctrl_q[CTRL_SYNC];
    assign tgt_addr = ctrl_q[CTRL_ADDR_LSB +: ADDR_W];
    assign sdr      = mode_q[MODE_SDR];
    assign sym8     = mode_q[MODE_SYM8];
    assign wpayload = wdata_q[WDATA_MSB -: SYM_W];

endmodule

// File: rtl/dse_fsm.sv
module dse_fsm
    import dse_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SYM_W  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       stream,
    input  logic       sync_req,
    input  logic       sync_in,
    input  logic       sdr,
    input  logic       sym8,
    input  logic       rd_req,
    input  logic       msb,
    output dse_state_t state,
    output logic       load,
    output logic       shift,
    output logic       reload,
    output logic       cap,
    output logic       commit,
    output logic       sclk,
    output logic       cs_n,
    output logic       sdo,
    output logic       busy
);

    localparam int CNT_W = $clog2(SYM_W);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] FULL_LAST  = CNT_W'(SYM_W - 1);
    localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(SYM_W / 2 - 1);

    dse_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             half_q;
    logic             ddr_q;
    logic             sym8_q;
    logic             rd_q;

    logic end_bit;
    logic last_addr;
    logic last_data;

    always_comb begin
        end_bit = 1'b0;
        if (state_q == ST_ADDR) end_bit = half_q;
        if (state_q == ST_DATA) end_bit = ddr_q ? 1'b1 : half_q;
    end

    assign last_addr = (cnt_q == ADDR_LAST);
    assign last_data = (cnt_q == (sym8_q ? HALF_LAST : FULL_LAST));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = sync_req ? ST_WAIT_SYNC : ST_SELECT;
            end
            ST_WAIT_SYNC: begin
                if (sync_in) state_d = ST_SELECT;
            end
            ST_SELECT: state_d = ST_ADDR;
            ST_ADDR: begin
                if (end_bit && last_addr) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (end_bit && last_data && !stream) state_d = ST_RELEASE;
            end
            ST_RELEASE: state_d = ST_DONE;
            ST_DONE: begin
                if (!go) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // bit counters and per-access latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
            ddr_q  <= 1'b0;
            sym8_q <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q  <= '0;
                    half_q <= 1'b0;
                    if (go) begin
                        ddr_q  <= !sdr;
                        sym8_q <= sym8;
                        rd_q   <= rd_req;
                    end
                end
                ST_ADDR: begin
                    if (end_bit) begin
                        half_q <= 1'b0;
                        cnt_q  <= last_addr ? '0 : cnt_q + 1'b1;
                    end else begin
                        half_q <= 1'b1;
                    end
                end
                ST_DATA: begin
                    if (end_bit) begin
                        half_q <= 1'b0;
                        cnt_q  <= last_data ? '0 : cnt_q + 1'b1;
                    end else begin
                        half_q <= 1'b1;
                    end
                end
                default: begin
                    cnt_q  <= '0;
                    half_q <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        load   = 1'b0;
        shift  = 1'b0;
        reload = 1'b0;
        cap    = 1'b0;
        commit = 1'b0;
        sclk   = 1'b0;
        cs_n   = 1'b1;
        sdo    = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            ST_IDLE: load = go;
            ST_WAIT_SYNC: busy = 1'b1;
            ST_SELECT: begin
                cs_n = 1'b0;
                busy = 1'b1;
            end
            ST_ADDR: begin
                cs_n  = 1'b0;
                busy  = 1'b1;
                sclk  = half_q;
                sdo   = msb;
                shift = end_bit;
            end
            ST_DATA: begin
                cs_n   = 1'b0;
                busy   = 1'b1;
                sclk   = ddr_q ? cnt_q[0] : half_q;
                sdo    = rd_q ? 1'b0 : msb;
                shift  = end_bit;
                cap    = end_bit;
                reload = end_bit && last_data && stream;
            end
            ST_RELEASE: begin
                cs_n   = 1'b0;
                busy   = 1'b1;
                commit = rd_q;
            end
            ST_DONE: busy = 1'b0;
            default: busy = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/dse_shifter.sv
module dse_shifter #(
    parameter int ADDR_W = 8,
    parameter int SYM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              reload,
    input  logic              shift,
    input  logic              cap,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SYM_W-1:0]  payload,
    input  logic              sdi,
    output logic              msb,
    output logic [SYM_W-1:0]  captured
);

    localparam int SH_W = ADDR_W + SYM_W;

    logic [SH_W-1:0]  sh_q;
    logic [SYM_W-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= {addr, payload};
        end else if (reload) begin
            sh_q <= {payload, {ADDR_W{1'b0}}};
        end else if (shift) begin
            sh_q <= {sh_q[SH_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (load) begin
            cap_q <= '0;
        end else if (cap) begin
            cap_q <= {cap_q[SYM_W-2:0], sdi};
        end
    end

    assign msb      = sh_q[SH_W-1];
    assign captured = cap_q;

endmodule

// File: rtl/dac_serial_engine.sv
module dac_serial_engine
    import dse_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int BUS_AW = 3,
    parameter int ADDR_W = 8,
    parameter int SYM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              sync_in,
    output logic              dac_sclk,
    output logic              dac_cs_n,
    output logic              dac_sdo,
    input  logic              dac_sdi
);

    localparam int HALF_W = SYM_W / 2;

    logic              go_w, stream_w, sync_req_w, sdr_w, sym8_w;
    logic [ADDR_W-1:0] tgt_addr_w;
    logic [SYM_W-1:0]  wpayload_w;
    logic [SYM_W-1:0]  payload_w;
    logic [SYM_W-1:0]  captured_w;
    logic              busy_w, commit_w;
    logic              load_w, shift_w, reload_w, cap_w, msb_w;
    logic              rd_req_w;
    dse_state_t        fsm_state;

    dse_regs #(
        .BUS_W (BUS_W),
        .BUS_AW(BUS_AW),
        .ADDR_W(ADDR_W),
        .SYM_W (SYM_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy     (busy_w),
        .rd_commit(commit_w),
        .rd_value (captured_w),
        .go       (go_w),
        .stream   (stream_w),
        .sync_req (sync_req_w),
        .tgt_addr (tgt_addr_w),
        .sdr      (sdr_w),
        .sym8     (sym8_w),
        .wpayload (wpayload_w)
    );

    assign rd_req_w = tgt_addr_w[ADDR_W-1];

    // left-justify the payload; reads shift out zeros
    always_comb begin
        if (rd_req_w)    payload_w = '0;
        else if (sym8_w) payload_w = {wpayload_w[SYM_W-1 -: HALF_W], {(SYM_W-HALF_W){1'b0}}};
        else             payload_w = wpayload_w;
    end

    dse_fsm #(
        .ADDR_W(ADDR_W),
        .SYM_W (SYM_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go_w),
        .stream  (stream_w),
        .sync_req(sync_req_w),
        .sync_in (sync_in),
        .sdr     (sdr_w),
        .sym8    (sym8_w),
        .rd_req  (rd_req_w),
        .msb     (msb_w),
        .state   (fsm_state),
        .load    (load_w),
        .shift   (shift_w),
        .reload  (reload_w),
        .cap     (cap_w),
        .commit  (commit_w),
        .sclk    (dac_sclk),
        .cs_n    (dac_cs_n),
        .sdo     (dac_sdo),
        .busy    (busy_w)
    );

    dse_shifter #(
        .ADDR_W(ADDR_W),
        .SYM_W (SYM_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_w),
        .reload  (reload_w),
        .shift   (shift_w),
        .cap     (cap_w),
        .addr    (tgt_addr_w),
        .payload (payload_w),
        .sdi     (dac_sdi),
        .msb     (msb_w),
        .captured(captured_w)
    );

endmodule

// File: rtl/dse_checker.sv
module dse_checker
    import dse_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       go,
    input logic       cs_n,
    input logic       sclk,
    input logic       sdo,
    input logic       sync_in,
    input dse_state_t st
);

    // R8: outside an access chip-select is released
    a_r8_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R4: serial clock parks low while deselected
    a_r4_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4: address bit held across its high half
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && sclk) |-> $stable(sdo));

    // R12: no start before the sync pulse
    a_r12_sync_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_SYNC && !sync_in) |=> (st == ST_WAIT_SYNC && cs_n));

    // R9: completion holds while launch stays set
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && go) |=> (st == ST_DONE));

endmodule

bind dac_serial_engine dse_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy_w),
    .go     (go_w),
    .cs_n   (dac_cs_n),
    .sclk   (dac_sclk),
    .sdo    (dac_sdo),
    .sync_in(sync_in),
    .st     (fsm_state)
);

// File: tb/dac_serial_engine_bench.sv
`timescale 1ns/1ps
module dac_serial_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd3;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sync_in = 1'b0;
    logic        dac_sclk, dac_cs_n, dac_sdo;
    logic        dac_sdi = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    // expected {cs_n, sclk, sdo, busy} per cycle, plus stimulus per cycle
    logic [3:0] expq[$];
    logic       sdiq[$];
    logic       syncq[$];
    string      tagq[$];

    always #2 clk = ~clk;

    dac_serial_engine u_dac_serial_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in),
        .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_sdo(dac_sdo),
        .dac_sdi(dac_sdi)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd3;
    endtask

    task automatic bus_read_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
        bus_addr = 3'd3;
    endtask

    task automatic push(input logic cs, input logic sc, input logic d, input logic b,
                        input logic si, input logic sy, input string tag);
        expq.push_back({cs, sc, d, b});
        sdiq.push_back(si);
        syncq.push_back(sy);
        tagq.push_back(tag);
    endtask

    // expected waveform of one access, from the requirements
    task automatic build(input logic [7:0] tgt, input bit sdr, input bit sym8, input int nsym,
                         input logic [15:0] p0, input logic [15:0] p1,
                         input logic [15:0] rpat, input int nwait);
        bit rd;
        int w;
        rd = tgt[7];
        w  = sym8 ? 8 : 16;
        expq.delete(); sdiq.delete(); syncq.delete(); tagq.delete();
        push(1, 0, 0, 0, 0, 0, "R3 launch");
        for (int i = 0; i < nwait; i++)
            push(1, 0, 0, 1, 0, (i == nwait - 1), "R12 wait");
        push(0, 0, 0, 1, 0, 0, "R3 select");
        for (int k = 7; k >= 0; k--) begin
            push(0, 0, tgt[k], 1, 0, 0, "R4 addr");
            push(0, 1, tgt[k], 1, 0, 0, "R4 addr");
        end
        for (int s = 0; s < nsym; s++) begin
            logic [15:0] pay;
            string tg;
            pay = (s == 0) ? p0 : p1;
            tg  = rd ? "R10 read" : (s > 0 ? "R11 stream" : (sdr ? "R5 R6 sdr" : "R5 R7 ddr"));
            for (int k = 0; k < w; k++) begin
                logic d;
                logic si;
                d  = rd ? 1'b0 : pay[15-k];
                si = rpat[w-1-k];
                if (sdr) begin
                    push(0, 0, d, 1, si, 0, tg);
                    push(0, 1, d, 1, si, 0, tg);
                end else begin
                    push(0, k[0], d, 1, si, 0, tg);
                end
            end
        end
        push(0, 0, 0, 1, 0, 0, "R8 release");
        for (int i = 0; i < 3; i++) push(1, 0, 0, 0, 0, 0, "R9 done");
    endtask

    // launch and compare every cycle; up to two register writes mid-access
    task automatic run(input logic [31:0] ctrl,
                       input int ia, input logic [2:0] aa, input logic [31:0] va,
                       input int ib, input logic [2:0] ab, input logic [31:0] vb);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = ctrl;
        for (int i = 0; i < expq.size(); i++) begin
            @(negedge clk);
            bus_wr = 1'b0; bus_addr = 3'd3;
            dac_sdi = sdiq[i];
            sync_in = syncq[i];
            #1 chk(tagq[i], {28'd0, dac_cs_n, dac_sclk, dac_sdo, bus_rdata[4]},
                   {28'd0, expq[i]});
            if (i == ia) begin bus_wr = 1'b1; bus_addr = aa; bus_wdata = va; end
            if (i == ib) begin bus_wr = 1'b1; bus_addr = ab; bus_wdata = vb; end
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd3; sync_in = 1'b0; dac_sdi = 1'b0;
        bus_write(3'd0, ctrl & 32'hFF00_0000);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                finished = 1;
                n_cmp++; n_bad++;
                $display("FAIL watchdog got %0d cycles expected completion", cycles);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        #1 chk("R1 pins", {29'd0, dac_cs_n, dac_sclk, dac_sdo}, 32'h4);
        chk("R1 status", bus_rdata, 32'h0);
        rst_n = 1'b1;
        bus_read_chk("R1 ctrl", 3'd0, 32'h0);
        bus_read_chk("R1 rdata", 3'd4, 32'h0);

        // R2 readback
        bus_write(3'd0, 32'hA500_0006);
        bus_read_chk("R2 ctrl", 3'd0, 32'hA500_0006);
        bus_write(3'd0, 32'h0);
        bus_write(3'd1, 32'h0001_4000);
        bus_read_chk("R2 mode", 3'd1, 32'h0001_4000);
        bus_write(3'd2, 32'h1234_5678);
        bus_read_chk("R2 wdata", 3'd2, 32'h1234_5678);

        // SDR 16-bit write
        bus_write(3'd1, 32'h0001_0000);
        bus_write(3'd2, 32'h00AB_CD00);
        build(8'h2A, 1, 0, 1, 16'hABCD, 16'h0, 16'h0, 0);
        run(32'h2A00_0001, -1, 0, 0, -1, 0, 0);

        // SDR 8-bit write, bits [15:8] ignored (R5)
        bus_write(3'd1, 32'h0001_4000);
        bus_write(3'd2, 32'h005A_7700);
        build(8'h15, 1, 1, 1, 16'h5A00, 16'h0, 16'h0, 0);
        run(32'h1500_0001, -1, 0, 0, -1, 0, 0);

        // DDR 16-bit write
        bus_write(3'd1, 32'h0000_0000);
        bus_write(3'd2, 32'h0012_3400);
        build(8'h40, 0, 0, 1, 16'h1234, 16'h0, 16'h0, 0);
        run(32'h4000_0001, -1, 0, 0, -1, 0, 0);

        // DDR 8-bit write
        bus_write(3'd1, 32'h0000_4000);
        bus_write(3'd2, 32'h00C6_0000);
        build(8'h33, 0, 1, 1, 16'hC600, 16'h0, 16'h0, 0);
        run(32'h3300_0001, -1, 0, 0, -1, 0, 0);

        // SDR 16-bit read
        bus_write(3'd1, 32'h0001_0000);
        bus_write(3'd2, 32'h00FF_FF00);
        build(8'h85, 1, 0, 1, 16'h0, 16'h0, 16'hC3A5, 0);
        run(32'h8500_0001, -1, 0, 0, -1, 0, 0);
        bus_read_chk("R10 rdata 16", 3'd4, 32'h0000_C3A5);

        // DDR 8-bit read
        bus_write(3'd1, 32'h0000_4000);
        build(8'h91, 0, 1, 1, 16'h0, 16'h0, 16'h006B, 0);
        run(32'h9100_0001, -1, 0, 0, -1, 0, 0);
        bus_read_chk("R10 rdata 8", 3'd4, 32'h0000_006B);

        // synchronized start
        bus_write(3'd1, 32'h0001_4000);
        bus_write(3'd2, 32'h00E1_0000);
        build(8'h07, 1, 1, 1, 16'hE100, 16'h0, 16'h0, 5);
        run(32'h0700_0005, -1, 0, 0, -1, 0, 0);

        // stream of two 16-bit symbols: new data during the first, stop during the second
        bus_write(3'd1, 32'h0001_0000);
        bus_write(3'd2, 32'h00AB_CD00);
        build(8'h10, 1, 0, 2, 16'hABCD, 16'hBEEF, 16'h0, 0);
        run(32'h1000_0003, 25, 3'd2, 32'h00BE_EF00, 60, 3'd0, 32'h1000_0000);

        bus_read_chk("R9 idle status", 3'd3, 32'h0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule